// File: doc/BRIEF.md
# Dual-Clock Real-Time Counter

This block is a 16-bit counter that ticks on a slow real-time clock, while software sees it through a byte-wide register bus on a fast system clock. Writes to the run control and to the counter are carried into the counter's clock domain through a toggle request/acknowledge handshake. While such a transfer is in flight, a busy bit is visible. A self-clearing request bit asks the counter domain for a snapshot of the running count and copies it into a readable register. Compare-match and overflow events return to the system domain as toggles and set sticky flags. Each flag drives an interrupt request output whose value is a 2-bit level.

Period and compare values are written straight into system-domain registers, which the counter domain reads directly. Software changes them only while the counter is stopped. Every 16-bit value is written low byte first. The low byte waits in a shared holding latch, and the whole word commits when the high byte is written.

The transfer controller has two states. `XF_IDLE` moves to `XF_WAIT` when the control register or the counter high byte is written. `XF_WAIT` returns to `XF_IDLE` once the synchronized acknowledge toggle matches the request toggle. The snapshot controller also has two states. `SN_IDLE` moves to `SN_WAIT` when the sync register is written with bit 4 set. `SN_WAIT` returns to `SN_IDLE` once the snapshot acknowledge matches the request, and it loads the readback register on that same edge.

Top module: `slc_top`

## Requirements
- R1: When bit 0 of the control register (address 0) has reached the counter domain and the period is nonzero, the count advances by one on every counter-clock rising edge. After bit 0 is cleared and that change has reached the counter domain, the count holds.
- R2: While the period register (address 6 low, 7 high) is zero, the count never changes, even when running.
- R3: On a counting edge where the count equals the period, the count becomes zero and the overflow flag (bit 0 of flag register, address 3) is set.
- R4: On a counting edge where the count equals the compare value (address 8 low, 9 high), the compare flag (bit 1 of address 3) is set.
- R5: Writing the low byte of any 16-bit register only loads a holding latch. Writing the high byte (counter address 5, period 7, compare 9) commits the full word. Only the counter high-byte write starts a counter transfer.
- R6: Bit 0 of the sync register (address 1) reads 1 from the cycle after an accepted control or counter-high write until the counter domain acknowledges it.
- R7: A control or counter-high write made while bit 0 of address 1 is 1 is ignored. The control readback and the transferred count keep the earlier value.
- R8: Writing 1 to bit 4 of address 1 makes that bit read 1 until a copy of the count has landed in the readback register (address 4 low, 5 high). The bit then clears by itself.
- R9: The interrupt control register (address 2) holds the compare level in bits 3:2 and the overflow level in bits 1:0. Each interrupt output equals its level when its flag is set, and is 0 otherwise.
- R10: Writing 1 to a bit of address 3 clears that flag. Writing 0 leaves the flag unchanged.
- R11: Reserved bits read as zero and ignore writes. These are bits 7:1 of address 0, bits 7:5 and 3:1 of address 1, and bits 7:4 of address 2.
- R12: After reset, every register reads zero and both interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the register bus |
| rtc_clk | input | 1 | Slow counter clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_cmp | output | 2 | Compare-match interrupt level request |
| irq_ovf | output | 2 | Overflow interrupt level request |

## Verification
The checks assume the counter clock is much slower than the system clock, so each toggle settles through two system flops well before the next counter edge. They also assume period and compare are changed only while the counter is stopped, because those registers cross domains without a handshake. The stimulus drives the counter clock as discrete pulses, each lasting about ten system cycles. It writes period and compare only after a stop has been acknowledged. This makes the number of counting edges exact, so every expected count and flag follows from the requirements alone.

// File: rtl/slc_pkg.sv
package slc_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 4'd0,
        A_SYNC = 4'd1,
        A_IEN  = 4'd2,
        A_FLAG = 4'd3,
        A_CNTL = 4'd4,
        A_CNTH = 4'd5,
        A_PERL = 4'd6,
        A_PERH = 4'd7,
        A_CMPL = 4'd8,
        A_CMPH = 4'd9
    } reg_addr_e;

    typedef enum logic { XF_IDLE, XF_WAIT } xfer_st_e;
    typedef enum logic { SN_IDLE, SN_WAIT } snap_st_e;
endpackage

// File: rtl/slc_sync2.sv
module slc_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/slc_rtc_core.sv
module slc_rtc_core
    import slc_pkg::*;
(
    input  logic              rtc_clk,
    input  logic              rst_n,
    input  logic              req_tog,
    input  logic              pay_is_cnt,
    input  logic [WORD_W-1:0] pay_data,
    input  logic              snap_tog,
    input  logic [WORD_W-1:0] per_i,
    input  logic [WORD_W-1:0] cmp_i,
    output logic              ack_tog,
    output logic              snap_ack,
    output logic [WORD_W-1:0] snap_val,
    output logic              ovf_tog,
    output logic              cmp_tog
);
    logic [1:0]        req_s;
    logic              req_seen, snap_seen, run_q;
    logic [WORD_W-1:0] cnt_q;

    slc_sync2 #(.W(2)) u_sync_in (
        .clk  (rtc_clk),
        .rst_n(rst_n),
        .d    ({req_tog, snap_tog}),
        .q    (req_s)
    );

    logic apply, ld_cnt, ld_ctl, tick, snap_go;
    assign apply   = req_s[1] ^ req_seen;
    assign ld_cnt  = apply & pay_is_cnt;
    assign ld_ctl  = apply & ~pay_is_cnt;
    assign tick    = run_q && (per_i != '0);
    assign snap_go = req_s[0] ^ snap_seen;

    always_ff @(posedge rtc_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_seen  <= 1'b0;
            snap_seen <= 1'b0;
            run_q     <= 1'b0;
            cnt_q     <= '0;
            ack_tog   <= 1'b0;
            snap_ack  <= 1'b0;
            snap_val  <= '0;
            ovf_tog   <= 1'b0;
            cmp_tog   <= 1'b0;
        end else begin
            req_seen  <= req_s[1];
            snap_seen <= req_s[0];
            if (apply)  ack_tog <= ~ack_tog;
            if (ld_ctl) run_q   <= pay_data[0];
            if (tick) begin
                if (cnt_q == per_i) ovf_tog <= ~ovf_tog;
                if (cnt_q == cmp_i) cmp_tog <= ~cmp_tog;
            end
            if (ld_cnt)    cnt_q <= pay_data;
            else if (tick) cnt_q <= (cnt_q == per_i) ? '0 : cnt_q + 1'b1;
            if (snap_go) begin
                snap_val <= cnt_q;
                snap_ack <= ~snap_ack;
            end
        end
    end

    // R2: a zero period freezes the count unless a load arrives
    a_r2_zero_period_hold: assert property (@(posedge rtc_clk) disable iff (!rst_n)
        (per_i == '0 && !ld_cnt) |=> cnt_q == $past(cnt_q));

    // R3: a running count at the period wraps to zero
    a_r3_wrap_to_zero: assert property (@(posedge rtc_clk) disable iff (!rst_n)
        (run_q && per_i != '0 && cnt_q == per_i && !ld_cnt) |=> cnt_q == '0);

    // R8: the snapshot only moves together with its acknowledge
    a_r8_snap_with_ack: assert property (@(posedge rtc_clk) disable iff (!rst_n)
        (snap_val != $past(snap_val)) |-> (snap_ack != $past(snap_ack)));
endmodule

// File: rtl/slc_top.sv
module slc_top
    import slc_pkg::*;
(
    input  logic              sys_clk,
    input  logic              rtc_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [1:0]        irq_cmp,
    output logic [1:0]        irq_ovf
);
    logic [BYTE_W-1:0] tmp_q;
    logic [3:0]        ien_q;
    logic              ctl_q, pay_cnt_q, req_q, snreq_q;
    logic [WORD_W-1:0] per_q, cmp_q, pay_q, cnt_rd_q;
    logic              ovf_f_q, cmp_f_q, ovf_seen, cmp_seen;
    xfer_st_e          xs_q, xs_d;
    snap_st_e          ss_q, ss_d;

    logic              ack_tog, snap_ack, ovf_tog, cmp_tog;
    logic [WORD_W-1:0] snap_val;
    logic [3:0]        back_s;

    slc_rtc_core u_core (
        .rtc_clk   (rtc_clk),
        .rst_n     (rst_n),
        .req_tog   (req_q),
        .pay_is_cnt(pay_cnt_q),
        .pay_data  (pay_q),
        .snap_tog  (snreq_q),
        .per_i     (per_q),
        .cmp_i     (cmp_q),
        .ack_tog   (ack_tog),
        .snap_ack  (snap_ack),
        .snap_val  (snap_val),
        .ovf_tog   (ovf_tog),
        .cmp_tog   (cmp_tog)
    );

    slc_sync2 #(.W(4)) u_sync_back (
        .clk  (sys_clk),
        .rst_n(rst_n),
        .d    ({ack_tog, snap_ack, ovf_tog, cmp_tog}),
        .q    (back_s)
    );

    logic wr_ctl, wr_cnth, xfer_go, snap_go, ovf_ev, cmp_ev, wr_flag;
    assign wr_ctl  = wr_en && (addr == A_CTRL);
    assign wr_cnth = wr_en && (addr == A_CNTH);
    assign wr_flag = wr_en && (addr == A_FLAG);
    assign xfer_go = (xs_q == XF_IDLE) && (wr_ctl || wr_cnth);
    assign snap_go = (ss_q == SN_IDLE) && wr_en && (addr == A_SYNC) && wdata[4];
    assign ovf_ev  = back_s[1] ^ ovf_seen;
    assign cmp_ev  = back_s[0] ^ cmp_seen;

    // next-state logic for both controllers
    always_comb begin
        xs_d = xs_q;
        unique case (xs_q)
            XF_IDLE: if (xfer_go)            xs_d = XF_WAIT;
            XF_WAIT: if (back_s[3] == req_q) xs_d = XF_IDLE;
        endcase
        ss_d = ss_q;
        unique case (ss_q)
            SN_IDLE: if (snap_go)              ss_d = SN_WAIT;
            SN_WAIT: if (back_s[2] == snreq_q) ss_d = SN_IDLE;
        endcase
    end

    // state registers
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            xs_q <= XF_IDLE;
            ss_q <= SN_IDLE;
        end else begin
            xs_q <= xs_d;
            ss_q <= ss_d;
        end
    end

    // register file and handshake outputs
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            tmp_q     <= '0;
            ien_q     <= '0;
            ctl_q     <= 1'b0;
            pay_cnt_q <= 1'b0;
            pay_q     <= '0;
            req_q     <= 1'b0;
            snreq_q   <= 1'b0;
            per_q     <= '0;
            cmp_q     <= '0;
            cnt_rd_q  <= '0;
            ovf_f_q   <= 1'b0;
            cmp_f_q   <= 1'b0;
            ovf_seen  <= 1'b0;
            cmp_seen  <= 1'b0;
        end else begin
            ovf_seen <= back_s[1];
            cmp_seen <= back_s[0];
            if (wr_en && (addr == A_CNTL || addr == A_PERL || addr == A_CMPL))
                tmp_q <= wdata;
            if (wr_en && addr == A_IEN)  ien_q <= wdata[3:0];
            if (wr_en && addr == A_PERH) per_q <= {wdata, tmp_q};
            if (wr_en && addr == A_CMPH) cmp_q <= {wdata, tmp_q};
            if (xfer_go) begin
                req_q     <= ~req_q;
                pay_cnt_q <= wr_cnth;
                if (wr_cnth) begin
                    pay_q <= {wdata, tmp_q};
                end else begin
                    pay_q <= {{(WORD_W-1){1'b0}}, wdata[0]};
                    ctl_q <= wdata[0];
                end
            end
            if (snap_go) snreq_q <= ~snreq_q;
            if (ss_q == SN_WAIT && ss_d == SN_IDLE) cnt_rd_q <= snap_val;
            if (ovf_ev)                      ovf_f_q <= 1'b1;
            else if (wr_flag && wdata[0])    ovf_f_q <= 1'b0;
            if (cmp_ev)                      cmp_f_q <= 1'b1;
            else if (wr_flag && wdata[1])    cmp_f_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:  rdata = {7'b0, ctl_q};
            A_SYNC:  rdata = {3'b0, ss_q == SN_WAIT, 3'b0, xs_q == XF_WAIT};
            A_IEN:   rdata = {4'b0, ien_q};
            A_FLAG:  rdata = {6'b0, cmp_f_q, ovf_f_q};
            A_CNTL:  rdata = cnt_rd_q[BYTE_W-1:0];
            A_CNTH:  rdata = cnt_rd_q[WORD_W-1:BYTE_W];
            A_PERL:  rdata = per_q[BYTE_W-1:0];
            A_PERH:  rdata = per_q[WORD_W-1:BYTE_W];
            A_CMPL:  rdata = cmp_q[BYTE_W-1:0];
            A_CMPH:  rdata = cmp_q[WORD_W-1:BYTE_W];
            default: rdata = '0;
        endcase
    end

    assign irq_cmp = cmp_f_q ? ien_q[3:2] : 2'b00;
    assign irq_ovf = ovf_f_q ? ien_q[1:0] : 2'b00;

    // R6: busy only rises after a bus write
    a_r6_busy_from_write: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $rose(xs_q == XF_WAIT) |-> $past(wr_en));

    // R7: payload and request toggle hold still while a transfer waits
    a_r7_payload_held: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (xs_q == XF_WAIT && $past(xs_q == XF_WAIT)) |-> ($stable(pay_q) && $stable(req_q)));

    // R8: readback holds the counter-domain snapshot once the request completes
    a_r8_readback_loaded: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ($past(ss_q == SN_WAIT) && ss_q == SN_IDLE) |-> cnt_rd_q == snap_val);

    // R9: no interrupt request without its flag
    a_r9_irq_needs_flag: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ((irq_cmp != 2'b00) |-> cmp_f_q) and ((irq_ovf != 2'b00) |-> ovf_f_q));
endmodule

// File: tb/slc_top_bench.sv
module slc_top_bench;
    logic       sys_clk = 1'b0;
    logic       rtc_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       wr_en   = 1'b0;
    logic [3:0] addr    = 4'd0;
    logic [7:0] wdata   = 8'd0;
    logic [7:0] rdata;
    logic [1:0] irq_cmp, irq_ovf;
    int total = 0;
    int bad   = 0;

    always #2 sys_clk = ~sys_clk;

    slc_top u_slc_top (
        .sys_clk(sys_clk), .rtc_clk(rtc_clk), .rst_n(rst_n),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
    );

    // fields: start, period, compare, extra ticks, expected count, expected {cmp,ovf}
    localparam logic [95:0] VEC [0:5] = '{
        {16'h0000, 16'd100,  16'd50,   16'd5, 16'd8,    16'd0},
        {16'd10,   16'd12,   16'd11,   16'd2, 16'd2,    16'd3},
        {16'h0000, 16'h0000, 16'h0000, 16'd4, 16'd0,    16'd0},
        {16'h1234, 16'hFFFF, 16'h1236, 16'd1, 16'h1238, 16'd2},
        {16'd5,    16'd5,    16'd9,    16'd2, 16'd4,    16'd1},
        {16'hFFFE, 16'hFFFF, 16'h0000, 16'd0, 16'd1,    16'd3}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge sys_clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge sys_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge sys_clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse();
        rtc_clk = 1'b1; #20;
        rtc_clk = 1'b0; #20;
    endtask

    task automatic settle(input logic [7:0] mask);
        logic [7:0] s;
        for (int i = 0; i < 8; i++) begin
            rd(4'd1, s);
            if ((s & mask) == 8'd0) return;
            pulse();
        end
    endtask

    task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
        wr(lo, v[7:0]);
        wr(lo + 4'd1, v[15:8]);
    endtask

    task automatic snap_read(output logic [15:0] v);
        logic [7:0] l, h;
        wr(4'd1, 8'h10);
        settle(8'h10);
        rd(4'd4, l);
        rd(4'd5, h);
        v = {h, l};
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        repeat (4) @(negedge sys_clk);
        rst_n = 1'b1;

        // R12: reset state
        for (int a = 0; a < 10; a++) begin
            rd(a[3:0], b);
            check("R12 reset register", b, 0);
        end
        check("R12 reset irq", {irq_cmp, irq_ovf}, 0);

        // R1 R2 R3 R4 R5: vector table (enable adds 0 ticks, stop adds 3)
        foreach (VEC[i]) begin
            wr16(4'd6, VEC[i][79:64]);
            wr16(4'd8, VEC[i][63:48]);
            wr16(4'd4, VEC[i][95:80]);
            settle(8'h01);
            wr(4'd3, 8'h03);
            wr(4'd0, 8'h01);
            settle(8'h01);
            for (int k = 0; k < int'(VEC[i][47:32]); k++) pulse();
            wr(4'd0, 8'h00);
            settle(8'h01);
            snap_read(w);
            check("R1 R2 R3 count after run", w, VEC[i][31:16]);
            rd(4'd3, b);
            check("R3 R4 flags after run", b, VEC[i][7:0]);
        end

        // R5: period/compare readback after high-byte commit
        rd(4'd7, b); check("R5 period high", b, 8'hFF);
        rd(4'd9, b); check("R5 compare high", b, 8'h00);
        wr(4'd6, 8'h77);
        rd(4'd6, b); check("R5 low byte held in latch", b, 8'hFF);

        // R9: interrupt levels (flags are {cmp,ovf}=11 from last vector)
        wr(4'd2, 8'hFF);
        rd(4'd2, b); check("R11 interrupt control reserved", b, 8'h0F);
        #1 check("R9 cmp level", irq_cmp, 3);
        check("R9 ovf level", irq_ovf, 3);
        wr(4'd2, 8'h09);
        #1 check("R9 cmp level 2", irq_cmp, 2);
        check("R9 ovf level 1", irq_ovf, 1);
        // R10: write-one-to-clear
        wr(4'd3, 8'h01);
        rd(4'd3, b); check("R10 clear ovf only", b, 8'h02);
        check("R10 irq ovf after clear", irq_ovf, 0);
        wr(4'd3, 8'h00);
        rd(4'd3, b); check("R10 zero write keeps flag", b, 8'h02);
        wr(4'd2, 8'h00);
        #1 check("R9 level zero masks", irq_cmp, 0);

        // R11: reserved bits
        wr(4'd1, 8'hEE);
        rd(4'd1, b); check("R11 sync reserved", b, 8'h00);
        wr(4'd0, 8'hFE);
        settle(8'h01);
        rd(4'd0, b); check("R11 control reserved", b, 8'h00);

        // R6 R7: busy flag and writes during busy
        wr16(4'd4, 16'h0011);
        rd(4'd1, b); check("R6 busy after counter write", b, 8'h01);
        wr16(4'd4, 16'h3322);
        wr(4'd0, 8'h01);
        rd(4'd0, b); check("R7 control write ignored", b, 8'h00);
        settle(8'h01);
        rd(4'd1, b); check("R6 busy clears", b, 8'h00);
        // R8: request bit visible then self-clearing
        wr(4'd1, 8'h10);
        rd(4'd1, b); check("R8 request pending", b, 8'h10);
        settle(8'h10);
        rd(4'd1, b); check("R8 request self-cleared", b, 8'h00);
        rd(4'd5, b); w[15:8] = b;
        rd(4'd4, b); w[7:0] = b;
        check("R7 counter write during busy ignored", w, 16'h0011);

        // R2: running with zero period stays frozen
        wr16(4'd6, 16'h0000);
        wr(4'd0, 8'h01);
        settle(8'h01);
        for (int k = 0; k < 5; k++) pulse();
        snap_read(w);
        check("R2 zero period hold", w, 16'h0011);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule